// File: doc/BRIEF.md
# Skew Line Deskew Lane Generator

This block builds the serial bit stream of an eleventh, auxiliary lane that travels beside ten parallel data lanes. A receiver at the far end compares this stream against the data lanes and realigns them bit by bit. In every bit time the block gets one parallel word holding the current bit of each data lane. It emits one deskew bit per bit time.

The deskew stream is made of five-bit elements. Each element carries four diagonal samples followed by one parity bit. In a data slot the block copies the bit of the lane that a rotating pointer selects. The pointer starts at the highest lane and steps down by one lane per data slot. After the lowest lane it wraps back to the highest. In a parity slot the time index still moves forward, so the data word of that bit time is not sampled. The parity bit covers the four samples of its own element. A small parameter table decides, element by element, whether that bit gives even or odd parity. The default table is even, even, odd, even, and it repeats.

One clock cycle equals one bit time. By default the output is registered, so the deskew bit that belongs to the word presented in cycle n appears on the output after the rising edge that ends cycle n.

Top module: `skew_line_gen`

## Requirements
- R1: While `rst_n` is low, `skew_bit` is 0. The first bit time after reset release is a data slot that samples lane 9 in element 0.
- R2: In a data slot the deskew bit equals `lane_data[p]`, where p is the current lane pointer and the word is the one presented in that same bit time.
- R3: The lane pointer drops by one after every data slot and wraps from lane 0 to lane 9. It keeps its value across a parity slot.
- R4: After exactly four data slots comes one parity slot, so every element is five bit times long. The word presented during a parity slot has no effect on the output.
- R5: In an even element the parity bit is the XOR of that element's four data bits, so the five bits hold an even number of ones.
- R6: In an odd element the parity bit is the inverted XOR of that element's four data bits, so the five bits hold an odd number of ones.
- R7: Element polarity follows the table: element 0 even, element 1 even, element 2 odd, element 3 even. The table then repeats from element 0, and the element count restarts at reset.
- R8: The deskew bit for the word presented in bit time n is driven on `skew_bit` after the rising clock edge that ends bit time n. It holds for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-time clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data | input | 10 | Current bit of each data lane; bit i is lane i |
| skew_bit | output | 1 | Serial deskew lane bit |

## Verification
The assertions assume one bit time per clock, a known value on every bit of `lane_data` in every cycle, and a reset that is released away from the rising edge. The bench keeps within these limits. It changes `lane_data` and `rst_n` only on falling edges and always drives full known words. It releases reset in the same falling edge in which it presents the first word of a new stream. It covers constant, walking-one and random words. It also flips the word during parity slots and applies a reset in the middle of an element.

// File: rtl/skew_line_pkg.sv
package skew_line_pkg;

   typedef enum logic {
      SLOT_DATA   = 1'b0,
      SLOT_PARITY = 1'b1
   } slot_kind_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/skew_lane_rotor.sv
module skew_lane_rotor
   import skew_line_pkg::*;
#(
   parameter int unsigned NUM_LANES = 10,
   localparam int unsigned LANE_W   = width_of(NUM_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [LANE_W-1:0] lane_sel
);

   localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(NUM_LANES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_sel <= TOP_LANE;
      end else if (advance) begin
         lane_sel <= (lane_sel == '0) ? TOP_LANE : lane_sel - 1'b1;
      end
   end

endmodule

// File: rtl/skew_element_seq.sv
module skew_element_seq
   import skew_line_pkg::*;
#(
   parameter int unsigned           GROUP_DATA = 4,
   parameter int unsigned           NUM_ELEMS  = 4,
   parameter logic [NUM_ELEMS-1:0]  ELEM_ODD   = 4'b0100
) (
   input  logic       clk,
   input  logic       rst_n,
   output slot_kind_e kind,
   output logic       odd_elem
);

   localparam int unsigned SLOT_W = width_of(GROUP_DATA + 1);
   localparam int unsigned ELEM_W = width_of(NUM_ELEMS);
   localparam logic [SLOT_W-1:0] PAR_SLOT  = SLOT_W'(GROUP_DATA);
   localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEMS - 1);

   logic [SLOT_W-1:0] slot_q;
   logic [ELEM_W-1:0] elem_q;

   assign kind = (slot_q == PAR_SLOT) ? SLOT_PARITY : SLOT_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (kind == SLOT_PARITY) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

   generate
      if (NUM_ELEMS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) elem_q <= '0;
            else        elem_q <= '0;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               elem_q <= '0;
            end else if (kind == SLOT_PARITY) begin
               elem_q <= (elem_q == LAST_ELEM) ? '0 : elem_q + 1'b1;
            end
         end
      end
   endgenerate

   assign odd_elem = ELEM_ODD[elem_q];

endmodule

// File: rtl/skew_parity_acc.sv
module skew_parity_acc
   import skew_line_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  slot_kind_e kind,
   input  logic       data_bit,
   input  logic       odd_elem,
   output logic       parity_bit
);

   logic acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
      end else if (kind == SLOT_PARITY) begin
         acc_q <= 1'b0;
      end else begin
         acc_q <= acc_q ^ data_bit;
      end
   end

   assign parity_bit = acc_q ^ odd_elem;

endmodule

// File: rtl/skew_line_gen.sv
module skew_line_gen
   import skew_line_pkg::*;
#(
   parameter int unsigned           NUM_LANES    = 10,
   parameter int unsigned           GROUP_DATA   = 4,
   parameter int unsigned           NUM_ELEMS    = 4,
   parameter logic [NUM_ELEMS-1:0]  ELEM_ODD     = 4'b0100,
   parameter bit                    REGISTER_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] lane_data,
   output logic                 skew_bit
);

   localparam int unsigned LANE_W = width_of(NUM_LANES);

   generate
      if (NUM_LANES < 2) begin : g_bad_lanes
         $error("skew_line_gen: NUM_LANES must be at least 2");
      end
      if (GROUP_DATA < 1) begin : g_bad_group
         $error("skew_line_gen: GROUP_DATA must be at least 1");
      end
      if (NUM_ELEMS < 1) begin : g_bad_elems
         $error("skew_line_gen: NUM_ELEMS must be at least 1");
      end
   endgenerate

   logic [LANE_W-1:0] lane_sel;
   slot_kind_e        kind;
   logic              odd_elem;
   logic              sampled;
   logic              parity_bit;
   logic              next_bit;

   skew_element_seq #(
      .GROUP_DATA (GROUP_DATA),
      .NUM_ELEMS  (NUM_ELEMS),
      .ELEM_ODD   (ELEM_ODD)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .odd_elem (odd_elem)
   );

   skew_lane_rotor #(
      .NUM_LANES (NUM_LANES)
   ) u_rotor (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (kind == SLOT_DATA),
      .lane_sel (lane_sel)
   );

   assign sampled = lane_data[lane_sel];

   skew_parity_acc u_par (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .data_bit   (sampled),
      .odd_elem   (odd_elem),
      .parity_bit (parity_bit)
   );

   assign next_bit = (kind == SLOT_PARITY) ? parity_bit : sampled;

   generate
      if (REGISTER_OUT) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) skew_bit <= 1'b0;
            else        skew_bit <= next_bit;
         end
      end else begin : g_out_comb
         assign skew_bit = rst_n & next_bit;
      end
   endgenerate

endmodule

// File: rtl/skew_line_chk.sv
module skew_line_chk
   import skew_line_pkg::*;
#(
   parameter int unsigned NUM_LANES    = 10,
   parameter int unsigned GROUP_DATA   = 4,
   parameter bit          REGISTER_OUT = 1'b1,
   localparam int unsigned LANE_W      = width_of(NUM_LANES),
   localparam int unsigned RUN_W       = width_of(GROUP_DATA + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LANES-1:0] lane_data,
   input logic                 skew_bit,
   input logic [LANE_W-1:0]    lane_sel,
   input slot_kind_e           kind
);

   localparam logic [LANE_W-1:0] TOP_LANE  = LANE_W'(NUM_LANES - 1);
   localparam logic [RUN_W-1:0]  GROUP_CNT = RUN_W'(GROUP_DATA);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_q <= '0;
      else if (kind == SLOT_DATA)  run_q <= run_q + 1'b1;
      else                         run_q <= '0;
   end

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |-> (lane_sel == TOP_LANE && kind == SLOT_DATA && !skew_bit)); // R1

   AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(kind) == SLOT_DATA) |->
      lane_sel == (($past(lane_sel) == '0) ? TOP_LANE : $past(lane_sel) - 1'b1)); // R3

   AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(kind) == SLOT_PARITY) |-> $stable(lane_sel)); // R3

   AST_PARITY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      kind == SLOT_PARITY |=> kind == SLOT_DATA); // R4

   AST_GROUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      kind == SLOT_PARITY |-> run_q == GROUP_CNT); // R4

   AST_NO_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      kind == SLOT_DATA |-> run_q < GROUP_CNT); // R4

   generate
      if (REGISTER_OUT) begin : g_reg_checks
         AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(kind) == SLOT_DATA) |->
            skew_bit == $past(lane_data[lane_sel])); // R2
      end
   endgenerate

endmodule

bind skew_line_gen skew_line_chk #(
   .NUM_LANES    (NUM_LANES),
   .GROUP_DATA   (GROUP_DATA),
   .REGISTER_OUT (REGISTER_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane_data (lane_data),
   .skew_bit  (skew_bit),
   .lane_sel  (lane_sel),
   .kind      (kind)
);

// File: tb/skew_line_gen_test.sv
module skew_line_gen_test;

   localparam int         NL  = 10;
   localparam int         GD  = 4;
   localparam int         NE  = 4;
   localparam logic [3:0] ODD = 4'b0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [NL-1:0] lane_data = '0;
   logic          skew_bit;

   always #5 clk = ~clk;

   skew_line_gen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_data (lane_data),
      .skew_bit  (skew_bit)
   );

   typedef struct {
      bit    val;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   tests = 0;
   int   fails = 0;
   bit   done  = 1'b0;

   int   m_lane, m_slot, m_elem;
   bit   m_acc, m_fresh;

   task automatic check(input bit act, input bit expv, input string tag);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: skew_bit=%0b expected %0b", tag, act, expv);
      end
   endtask

   task automatic model_reset();
      m_lane  = NL - 1;
      m_slot  = 0;
      m_elem  = 0;
      m_acc   = 1'b0;
      m_fresh = 1'b1;
   endtask

   function automatic bit in_parity_slot();
      return m_slot == GD;
   endfunction

   // Driver: called at a falling edge, presents one word, queues the
   // expected deskew bit, returns at the next falling edge.
   task automatic drive(input logic [NL-1:0] w, input string note);
      exp_t e;
      lane_data = w;
      if (m_slot < GD) begin
         e.val = w[m_lane];
         e.tag = m_fresh ? {note, " R1 first slot lane 9"} : {note, " R2/R3 data slot"};
         m_acc ^= e.val;
         m_lane = (m_lane == 0) ? NL - 1 : m_lane - 1;
         m_slot++;
      end else begin
         e.val = m_acc ^ ODD[m_elem];
         e.tag = ODD[m_elem] ? {note, " R6/R7 odd parity"} : {note, " R5/R7 even parity"};
         m_acc  = 1'b0;
         m_slot = 0;
         m_elem = (m_elem + 1) % NE;
      end
      m_fresh = 1'b0;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: one cycle of latency, sampled just after the rising edge (R8)
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check(skew_bit, e.val, {e.tag, " R8"});
      end
   end

   task automatic do_reset();
      rst_n     = 1'b0;
      lane_data = NL'($urandom);
      @(negedge clk);
      check(skew_bit, 1'b0, "R1 reset output low");
      lane_data = '1;
      @(negedge clk);
      check(skew_bit, 1'b0, "R1 reset output low with ones");
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      #1 rst_n = 1'b0;
      @(negedge clk);
      do_reset();

      // zeros: parity bits show the polarity table alone (R7)
      for (int i = 0; i < 40; i++) drive('0, "zeros");
      for (int i = 0; i < 40; i++) drive('1, "ones");
      for (int i = 0; i < 60; i++) drive(NL'(1) << (i % NL), "walk1");
      for (int i = 0; i < 50; i++) drive(10'h2AA, "alt");
      for (int i = 0; i < 400; i++) drive(NL'($urandom), "random");

      // R4: parity-slot words are the complement of the data-slot word
      for (int i = 0; i < 200; i++) begin
         if (in_parity_slot()) drive(~10'h2B5, "R4 flipped");
         else                  drive(10'h2B5, "R4 steady");
      end
      for (int i = 0; i < 100; i++) begin
         if (in_parity_slot()) drive(NL'($urandom), "R4 noise");
         else                  drive('0, "R4 quiet");
      end

      // reset in the middle of an element, then restart (R1, R7)
      for (int i = 0; i < 23; i++) drive(NL'($urandom), "pre-reset");
      do_reset();
      for (int i = 0; i < 20; i++) drive('0, "R7 restart");
      for (int i = 0; i < 100; i++) drive(NL'($urandom), "post-reset");

      @(posedge clk);
      #2;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule